// File: doc/BRIEF.md
# Byte-Parallel Stream Bus Transmitter

This block sits on the demultiplexer side of an 8-bit parallel streaming bus. It takes packet bytes from an upstream valid/ready source, where each byte carries a start-of-packet flag. It sends every byte to a downstream receiver as one bus transfer. A transfer puts the byte on the data lines and raises the valid line at least one system clock ahead of a single strobe rising edge. Data and valid stay put until the strobe has fallen. A sync line marks packet starts, and a receiver busy line throttles the flow.

The sync line rises with the first byte of each packet. It then stays high through a programmable number of byte transfers, two by default. It stays high across idle gaps until that count is reached. If a packet is shorter than the hold count, sync runs on into the next packet. A new start-of-packet byte restarts the count.

A programmable spacing puts a floor under the number of system clocks between strobe rising edges. When the source has nothing to send, the bus stays quiet and no filler is sent. The receiver busy line may be asynchronous, so it passes through a two-flop synchronizer. Once it is seen high, no new byte is accepted. A byte that was already accepted still completes. Everything runs on one clock with an asynchronous active-low reset whose release is synchronized inside the block.

Top module: `stream_bus_tx`

## Requirements
- R1: Every byte accepted from the source (src_valid and src_ready high at a clock edge) appears on bus_data at exactly one bus_strb rising edge. Bytes keep their order, and none is lost or repeated.
- R2: bus_vld is high and bus_data holds the byte for at least one clock before bus_strb rises. bus_strb stays high for exactly one clock. bus_vld and bus_data are unchanged in the first clock after bus_strb falls.
- R3: Two bus_strb rising edges are never closer than STRB_MIN_CLKS clocks apart (STRB_MIN_CLKS >= 4, default 6). With a source that is always ready and no back-pressure, the spacing is exactly STRB_MIN_CLKS.
- R4: bus_sync rises in the same clock as bus_vld for a byte that carries src_sop = 1, and it is high at that byte's strobe edge.
- R5: Count byte position from the latest start-of-packet byte, which is position 0. bus_sync is high at the strobe of positions 0 to SYNC_HOLD-1 (default 2), and low for later positions. It stays high during idle gaps before position SYNC_HOLD-1 has been sent. It falls in the clock where bus_vld drops after that byte.
- R6: A packet shorter than SYNC_HOLD keeps bus_sync high into the following packet. Any start-of-packet byte sets the position back to 0.
- R7: Once rx_busy has been high for 5 or more consecutive clocks, no new bus_strb rising edge occurs until it drops. Transfers resume after it goes low.
- R8: With no byte offered by the source, bus_vld and bus_strb stay low and no strobe edge is produced.
- R9: While reset is asserted, bus_vld, bus_strb, bus_sync and src_ready are low. Within 3 clocks after reset release, src_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Source offers a byte |
| src_ready | output | 1 | Block takes the offered byte at this edge |
| src_data | input | 8 | Offered byte |
| src_sop | input | 1 | Offered byte starts a packet |
| rx_busy | input | 1 | Receiver back-pressure, may be asynchronous |
| bus_data | output | 8 | Bus data lines |
| bus_vld | output | 1 | Bus valid line |
| bus_strb | output | 1 | Bus strobe, one rising edge per byte |
| bus_sync | output | 1 | Packet start marker on the bus |

## Verification
The assertions assume STRB_MIN_CLKS is at least 4 and that src_sop is meaningful only while src_valid is high. They also assume rx_busy is sampled only through the synchronizer, so the back-pressure property looks two clocks behind the synchronized level rather than at the raw pin. The stimulus changes src_valid, src_data, src_sop and rx_busy one time unit after a rising edge. It holds each busy window well past the four-clock reaction time, so only strobes that come after the synchronizer and the accepted byte have settled are treated as violations.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_HIGH  = 2'd2,
    TX_HOLD  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/stx_busy_sync.sv
module stx_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic busy_async_i,
  output logic busy_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = busy_async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], busy_async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign busy_o = chain_q[STAGES-1];
endmodule

// File: rtl/stx_pacer.sv
module stx_pacer #(
  parameter int STRB_MIN_CLKS = 6
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic rise_next_i,
  output logic pace_ok_o
);
  localparam int CW = $clog2(STRB_MIN_CLKS + 1);
  localparam logic [CW-1:0] CNT_SAT   = CW'(STRB_MIN_CLKS);
  localparam logic [CW-1:0] READY_AT  = CW'(STRB_MIN_CLKS - 2);
  localparam logic [CW-1:0] RISE_MIN  = CW'(STRB_MIN_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = rise_next_i || (cnt_q != CNT_SAT);
    cnt_d  = rise_next_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_SAT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pace_ok_o = (cnt_q >= READY_AT);

  // R3
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_next_i |-> (cnt_q >= RISE_MIN));
endmodule

// File: rtl/stx_sync_track.sv
module stx_sync_track #(
  parameter int SYNC_HOLD = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic sop_i,
  input  logic hold_end_i,
  output logic sync_o
);
  localparam int PW = $clog2(SYNC_HOLD + 1);
  localparam logic [PW-1:0] POS_SAT  = PW'(SYNC_HOLD);
  localparam logic [PW-1:0] POS_LAST = PW'(SYNC_HOLD - 1);

  logic [PW-1:0] pos_q, pos_d;
  logic          sync_q, sync_d;
  logic          pos_en;

  always_comb begin
    pos_en = accept_i;
    if (sop_i)              pos_d = '0;
    else if (pos_q == POS_SAT) pos_d = POS_SAT;
    else                    pos_d = pos_q + 1'b1;

    sync_d = sync_q;
    if (accept_i && sop_i)                        sync_d = 1'b1;
    else if (hold_end_i && (pos_q >= POS_LAST))   sync_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= POS_SAT;
    else if (pos_en) pos_q <= pos_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_d;
  end

  assign sync_o = sync_q;

  // R4
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(accept_i && sop_i));

  // R5
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(sync_q) |-> $past(hold_end_i));
endmodule

// File: rtl/stx_byte_seq.sv
module stx_byte_seq
  import stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              pace_ok_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              rise_next_o,
  output logic              hold_end_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              vld_o,
  output logic              strb_o
);
  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] data_q;
  logic              vld_q, vld_d;
  logic              strb_q, strb_d;

  always_comb begin
    ready_o  = run_i && (state_q == TX_IDLE) && pace_ok_i && !busy_i;
    accept_o = ready_o && valid_i;
    state_d  = state_q;
    case (state_q)
      TX_IDLE:  if (accept_o) state_d = TX_SETUP;
      TX_SETUP: state_d = TX_HIGH;
      TX_HIGH:  state_d = TX_HOLD;
      TX_HOLD:  state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
    vld_d       = (state_d != TX_IDLE);
    strb_d      = (state_d == TX_HIGH);
    rise_next_o = (state_q == TX_SETUP);
    hold_end_o  = (state_q == TX_HOLD);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      vld_q   <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      strb_q  <= strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (accept_o) data_q <= data_i;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
  assign strb_o = strb_q;

  // R2
  vld_lead_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(strb_q) |-> $past(vld_q));

  // R2
  strb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    strb_q |=> (!strb_q && vld_q && $stable(data_q)));

  // R8
  strb_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !vld_q |-> !strb_q);

  // R1
  no_overtake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ready_o && valid_i) |-> !vld_q);
endmodule

// File: rtl/stream_bus_tx.sv
module stream_bus_tx
  import stx_pkg::*;
#(
  parameter int STRB_MIN_CLKS = 6,
  parameter int SYNC_HOLD     = 2,
  parameter int BUSY_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_sop,
  input  logic              rx_busy,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_vld,
  output logic              bus_strb,
  output logic              bus_sync
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       busy_s;
  logic       pace_ok;
  logic       accept;
  logic       rise_next;
  logic       hold_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  stx_busy_sync #(.STAGES(BUSY_STAGES)) u_busy (
    .clk          (clk),
    .rst_ni       (rst_core_n),
    .busy_async_i (rx_busy),
    .busy_o       (busy_s)
  );

  stx_pacer #(.STRB_MIN_CLKS(STRB_MIN_CLKS)) u_pacer (
    .clk         (clk),
    .rst_ni      (rst_core_n),
    .rise_next_i (rise_next),
    .pace_ok_o   (pace_ok)
  );

  stx_byte_seq u_seq (
    .clk         (clk),
    .rst_ni      (rst_core_n),
    .run_i       (rst_core_n),
    .valid_i     (src_valid),
    .data_i      (src_data),
    .busy_i      (busy_s),
    .pace_ok_i   (pace_ok),
    .ready_o     (src_ready),
    .accept_o    (accept),
    .rise_next_o (rise_next),
    .hold_end_o  (hold_end),
    .data_o      (bus_data),
    .vld_o       (bus_vld),
    .strb_o      (bus_strb)
  );

  stx_sync_track #(.SYNC_HOLD(SYNC_HOLD)) u_sync (
    .clk        (clk),
    .rst_ni     (rst_core_n),
    .accept_i   (accept),
    .sop_i      (src_sop),
    .hold_end_i (hold_end),
    .sync_o     (bus_sync)
  );

  // R7
  no_strobe_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(bus_strb) |-> !$past(busy_s, 2));

  // R5
  sync_falls_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(bus_sync) |-> ($past(bus_vld) && !bus_vld));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |-> (!bus_vld && !bus_strb && !bus_sync && !src_ready));
endmodule

// File: tb/sim_stream_bus_tx.sv
module sim_stream_bus_tx;
  localparam int CLK_PERIOD = 10;
  localparam int STRB_MIN   = 6;
  localparam int HOLD       = 2;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_valid, src_ready, src_sop, rx_busy;
  logic [7:0] src_data, bus_data;
  logic       bus_vld, bus_strb, bus_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_bus_tx #(.STRB_MIN_CLKS(STRB_MIN), .SYNC_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_sop(src_sop), .rx_busy(rx_busy),
    .bus_data(bus_data), .bus_vld(bus_vld), .bus_strb(bus_strb), .bus_sync(bus_sync)
  );

  int checks = 0;
  int failures = 0;
  int pushed = 0;
  int rises = 0;
  int exact = 0;
  int since = 0;
  int busy_run = 0;
  int bpos = HOLD;
  bit mon_en = 0;
  bit done = 0;
  logic [8:0] exq[$];
  logic       prev_strb = 0, prev_vld = 0;
  logic [7:0] prev_data = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sop);
    src_valid = 1'b1; src_data = d; src_sop = sop;
    forever begin
      @(negedge clk);
      if (src_ready) break;
    end
    @(posedge clk); #1;
    src_valid = 1'b0; src_sop = 1'b0;
    if (sop) bpos = 0;
    else if (bpos < HOLD) bpos++;
    exq.push_back({(bpos < HOLD), d});
    pushed++;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] base, input int gap);
    for (int i = 0; i < len; i++) begin
      send_byte(base + 8'(i), (i == 0));
      if (gap > 0) wait_clks(gap);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exq.size() != 0; i++) @(posedge clk);
    wait_clks(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      busy_run = rx_busy ? busy_run + 1 : 0;
      since++;
      if (bus_strb && !prev_strb) begin
        rises++;
        if (rises > 1) begin
          chk(since >= STRB_MIN, "R3 strobe spacing", since, STRB_MIN);
          if (since == STRB_MIN) exact++;
        end
        since = 0;
        chk(prev_vld && (prev_data == bus_data), "R2 data/vld lead", int'(prev_data), int'(bus_data));
        chk(busy_run < 5, "R7 strobe while busy", busy_run, 0);
        if (exq.size() == 0) begin
          chk(0, "R1 unexpected byte", int'(bus_data), -1);
        end else begin
          logic [8:0] e;
          e = exq.pop_front();
          chk(bus_data == e[7:0], "R1 byte value", int'(bus_data), int'(e[7:0]));
          chk(bus_sync == e[8], "R5 sync at strobe", int'(bus_sync), int'(e[8]));
        end
      end
      if (prev_strb && bus_strb) chk(0, "R2 strobe width", 2, 1);
      if (prev_strb && !bus_strb)
        chk(bus_vld && (bus_data == prev_data), "R2 hold past fall", int'(bus_vld), 1);
      prev_strb = bus_strb; prev_vld = bus_vld; prev_data = bus_data;
    end
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    finish_run();
  end

  initial begin : stim
    int r0;
    rst_n = 1'b0; src_valid = 0; src_sop = 0; src_data = 0; rx_busy = 0;
    wait_clks(4);
    // R9 reset state
    chk(!bus_vld && !bus_strb && !bus_sync, "R9 outputs in reset", int'({bus_vld, bus_strb, bus_sync}), 0);
    chk(!src_ready, "R9 ready in reset", int'(src_ready), 0);
    rst_n = 1'b1;
    mon_en = 1;
    wait_clks(3);
    chk(src_ready, "R9 ready after release", int'(src_ready), 1);

    // R1 R3 R4 R5: back-to-back packet
    send_pkt(5, 8'h10, 0);
    drain();
    chk(!bus_sync, "R5 sync low after packet", int'(bus_sync), 0);

    // R8 idle: nothing offered
    r0 = rises;
    wait_clks(30);
    chk(rises == r0, "R8 no filler strobes", rises - r0, 0);
    chk(!bus_vld && !bus_strb, "R8 bus quiet", int'({bus_vld, bus_strb}), 0);

    // R6 single-byte packet, gap, then next packet
    send_pkt(1, 8'hA0, 0);
    wait_clks(20);
    chk(bus_sync && !bus_vld, "R6 sync held in gap", int'(bus_sync), 1);
    send_pkt(3, 8'hB0, 0);
    drain();
    chk(!bus_sync, "R6 sync low after follow-on", int'(bus_sync), 0);

    // R6 run of single-byte packets
    send_pkt(1, 8'hC0, 0);
    send_pkt(1, 8'hC1, 0);
    send_pkt(1, 8'hC2, 0);
    send_pkt(2, 8'hC8, 0);
    drain();
    chk(!bus_sync, "R6 sync low after run", int'(bus_sync), 0);

    // R5 gap inside packet before position 1
    send_byte(8'hD0, 1'b1);
    wait_clks(12);
    chk(bus_sync, "R5 sync held mid-packet gap", int'(bus_sync), 1);
    send_byte(8'hD1, 1'b0);
    send_byte(8'hD2, 1'b0);
    drain();

    // R7 back-pressure: busy raised mid-packet
    r0 = rises;
    fork
      send_pkt(8, 8'hE0, 0);
      begin
        wait_clks(10);
        rx_busy = 1'b1;
        wait_clks(8);
        r0 = rises;
        wait_clks(40);
        chk(rises == r0, "R7 no strobes while busy", rises - r0, 0);
        rx_busy = 1'b0;
      end
    join
    drain();

    // end-of-run totals
    chk(exq.size() == 0, "R1 queue drained", exq.size(), 0);
    chk(rises == pushed, "R1 strobe count", rises, pushed);
    chk(exact > 0, "R3 full-rate spacing seen", exact, 1);
    finish_run();
  end
endmodule